// File: doc/BRIEF.md
# Cascaded Ring Clock-Enable Divider

This block turns a fast clock into a slow, periodic clock-enable pulse without a wide binary counter. The division ratio is the input frequency over the output frequency. While the design elaborates, the ratio is split into prime factors. Each factor must lie between 2 and 31, and each becomes one short circulating one-hot ring of that length.

The rings form a cascade. The first ring rotates on every cycle. Each later ring rotates only on cycles when every earlier ring sits at its last position, so the whole chain wraps once per ratio cycles. The enable comes from a register and stays in the input clock domain. No derived clock is produced.

With no duty fraction given, the enable is high for one cycle in each period. With a duty fraction, the enable rises at the start of each period. It falls when the ring positions together spell out the chosen high time, so no separate counter is needed. A ratio below 2, a prime factor above 31, or a duty fraction outside the open interval (0, 1) stops elaboration.

Top module: `ring_prescaler`

## Requirements
- R1: The enable repeats with a period of exactly IN_FREQ_HZ / OUT_FREQ_HZ input clock cycles.
- R2: A ratio with repeated factors (for example 60 = 2·2·3·5) gives the correct period and high time.
- R3: With DUTY = 0.0 (no duty given), `ce_o` is high for exactly one cycle per period.
- R4: With 0 < DUTY < 1, `ce_o` is high for round(DUTY·ratio) consecutive cycles, starting at the first cycle of each period.
- R5: The high time is clamped to at least 1 and at most ratio−1 cycles.
- R6: While `rst_n_i` is low at a clock edge, `ce_o` is 0 after that edge. After release, the first high cycle of `ce_o` appears exactly ratio edges later, and a second reset restarts the phase from zero.
- R7: A ratio that is a single prime (for example 29) gives the correct period and high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| ce_o | output | 1 | Registered clock-enable output |

## Verification
The assertions assume that reset is held low for at least one clock edge before checking starts. They also assume the clock runs without gaps, so that cycles since the last rise equal edges seen. The high-time property assumes that any fall outside reset is a natural end of the high phase. The bench keeps within these assumptions: it asserts reset only at falling clock edges and holds it for several cycles. It applies one mid-period reset and never stops the clock. It runs five configurations side by side, covering a repeated-factor ratio with and without a duty fraction, a prime ratio, and ratios that hit both ends of the clamp.

// File: rtl/prescale_pkg.sv
// Package: elaboration-time arithmetic for the ring prescaler.
// Assumes every ratio handed in is a positive int; factors are taken in
// ascending order, and the same order is used for stage placement.
package prescale_pkg;

    localparam int MIN_FACTOR = 2;
    localparam int MAX_FACTOR = 31;

    // Value left after removing all factors in [MIN_FACTOR, MAX_FACTOR].
    function automatic int leftover(input int ratio);
        int n;
        n = ratio;
        for (int p = MIN_FACTOR; p <= MAX_FACTOR; p++) begin
            while (n > 1 && (n % p) == 0) n = n / p;
        end
        return n;
    endfunction

    // Number of factors (with repetition) found in the allowed range.
    function automatic int factor_count(input int ratio);
        int n;
        int cnt;
        n   = ratio;
        cnt = 0;
        for (int p = MIN_FACTOR; p <= MAX_FACTOR; p++) begin
            while (n > 1 && (n % p) == 0) begin
                n   = n / p;
                cnt = cnt + 1;
            end
        end
        return cnt;
    endfunction

    // The k-th factor in ascending order; 2 if k is out of range.
    function automatic int factor_at(input int ratio, input int k);
        int n;
        int idx;
        int res;
        n   = ratio;
        idx = 0;
        res = MIN_FACTOR;
        for (int p = MIN_FACTOR; p <= MAX_FACTOR; p++) begin
            while (n > 1 && (n % p) == 0) begin
                if (idx == k) res = p;
                n   = n / p;
                idx = idx + 1;
            end
        end
        return res;
    endfunction

    // Ring position of stage k when the whole cascade is at phase ph.
    function automatic int digit_at(input int ratio, input int k, input int ph);
        int div;
        div = 1;
        for (int j = 0; j < k; j++) div = div * factor_at(ratio, j);
        return (ph / div) % factor_at(ratio, k);
    endfunction

    // High time in cycles: 1 when no duty is given, else rounded and clamped.
    function automatic int high_cycles(input real duty, input int ratio);
        int h;
        if (duty == 0.0) return 1;
        h = int'(duty * real'(ratio));
        if (h < 1) h = 1;
        if (h > ratio - 1) h = ratio - 1;
        return h;
    endfunction

endpackage

// File: rtl/ring_stage.sv
// Module: one circulating one-hot ring of LEN positions.
// Rotates by one position when adv_i is high. tap_o marks the last
// position, match_o marks position MATCH_POS. Assumes LEN >= 2.
module ring_stage #(
    parameter int LEN       = 2,
    parameter int MATCH_POS = 0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic adv_i,
    output logic tap_o,
    output logic match_o
);

    logic [LEN-1:0] ring_q;

    // Rotate the single hot bit upward; reset puts it at position 0.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)   ring_q <= {{(LEN-1){1'b0}}, 1'b1};
        else if (adv_i) ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
    end

    assign tap_o   = ring_q[LEN-1];
    assign match_o = ring_q[MATCH_POS];

endmodule

// File: rtl/ring_cascade.sv
// Module: chain of rings whose lengths multiply to RATIO.
// wrap_o is high in the last phase of the period (every ring at its tap).
// fall_o is high in phase FALL_PHASE. Assumes RATIO has been checked to
// factor fully into [2, 31] and NSTG equals that factor count.
module ring_cascade #(
    parameter int RATIO      = 60,
    parameter int NSTG       = 4,
    parameter int FALL_PHASE = 0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic wrap_o,
    output logic fall_o
);

    logic [NSTG:0]   en_chain;
    logic [NSTG-1:0] tap_vec;
    logic [NSTG-1:0] hit_vec;

    assign en_chain[0] = 1'b1;

    // One ring per factor; each ring advances only when all earlier rings wrap.
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        localparam int F_LEN = prescale_pkg::factor_at(RATIO, g);
        localparam int F_POS = prescale_pkg::digit_at(RATIO, g, FALL_PHASE);

        ring_stage #(
            .LEN       (F_LEN),
            .MATCH_POS (F_POS)
        ) u_ring (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .adv_i   (en_chain[g]),
            .tap_o   (tap_vec[g]),
            .match_o (hit_vec[g])
        );

        assign en_chain[g+1] = en_chain[g] & tap_vec[g];
    end

    assign wrap_o = en_chain[NSTG];
    assign fall_o = &hit_vec;

endmodule

// File: rtl/ce_shaper.sv
// Module: output register for the enable. Set on the period wrap, cleared
// on the fall phase. Assumes wrap_i and fall_i are never high together.
module ce_shaper (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic wrap_i,
    input  logic fall_i,
    output logic ce_o
);

    // Hold the enable between the rise and fall phases.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)    ce_o <= 1'b0;
        else if (wrap_i) ce_o <= 1'b1;
        else if (fall_i) ce_o <= 1'b0;
    end

endmodule

// File: rtl/ring_prescaler.sv
// Module: clock-enable divider built from a factorized ring cascade.
// ratio = IN_FREQ_HZ / OUT_FREQ_HZ. DUTY = 0.0 selects one-cycle pulses.
// Otherwise DUTY lies in (0, 1) and sets the high fraction. Elaboration
// stops on an unusable ratio or duty value.
module ring_prescaler #(
    parameter int  IN_FREQ_HZ  = 100_000_000,
    parameter int  OUT_FREQ_HZ = 1,
    parameter real DUTY        = 0.0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic ce_o
);

    localparam int RATIO      = IN_FREQ_HZ / OUT_FREQ_HZ;
    localparam int NFAC       = prescale_pkg::factor_count(RATIO);
    localparam int NSTG       = (NFAC < 1) ? 1 : NFAC;
    localparam int HIGH_CYC   = prescale_pkg::high_cycles(DUTY, RATIO);
    localparam int FALL_PHASE = HIGH_CYC - 1;

    // Elaboration guards on the ratio and the duty fraction.
    if (RATIO < 2 || prescale_pkg::leftover(RATIO) != 1) begin : g_bad_ratio
        $fatal(1, "ring_prescaler: ratio must be >= 2 with all prime factors <= 31");
    end
    if (DUTY != 0.0 && (DUTY <= 0.0 || DUTY >= 1.0)) begin : g_bad_duty
        $fatal(1, "ring_prescaler: duty fraction must lie strictly between 0 and 1");
    end

    logic wrap_w;
    logic fall_w;

    ring_cascade #(
        .RATIO      (RATIO),
        .NSTG       (NSTG),
        .FALL_PHASE (FALL_PHASE)
    ) u_cascade (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .wrap_o  (wrap_w),
        .fall_o  (fall_w)
    );

    ce_shaper u_shaper (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .wrap_i  (wrap_w),
        .fall_i  (fall_w),
        .ce_o    (ce_o)
    );

endmodule

// File: rtl/ring_prescaler_checker.sv
// Checker: timing properties of ce_o, observed at the ports only.
// Assumes a free-running clock and reset held for at least one edge.
module ring_prescaler_checker #(
    parameter int RATIO = 2,
    parameter int HIGH  = 1
) (
    input logic clk_i,
    input logic rst_n_i,
    input logic ce_o
);

    logic        ce_q;
    logic        seen_q;
    logic [31:0] per_cnt;
    logic [31:0] hi_cnt;
    logic [31:0] rel_cnt;
    logic        rise_w;

    assign rise_w = ce_o && !ce_q;

    // Track cycles since the last rise, high samples, and edges since release.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ce_q    <= 1'b0;
            seen_q  <= 1'b0;
            per_cnt <= '0;
            hi_cnt  <= '0;
            rel_cnt <= '0;
        end else begin
            ce_q    <= ce_o;
            per_cnt <= rise_w ? 32'd1 : per_cnt + 32'd1;
            hi_cnt  <= rise_w ? 32'd1 : (ce_o ? hi_cnt + 32'd1 : hi_cnt);
            if (rise_w) seen_q <= 1'b1;
            if (rel_cnt != 32'hFFFF_FFFF) rel_cnt <= rel_cnt + 32'd1;
        end
    end

    // R6: reset clears the enable.
    p_reset_clear_r6: assert property (@(posedge clk_i) !rst_n_i |=> !ce_o);

    // R6: first rise comes exactly RATIO edges after release.
    p_first_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rise_w && !seen_q) |-> (rel_cnt == RATIO));

    // R1: rises are RATIO cycles apart.
    p_period_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rise_w && seen_q) |-> (per_cnt == RATIO));

    // R4: each high phase lasts HIGH cycles.
    p_high_len_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!ce_o && ce_q) |-> (hi_cnt == HIGH));

endmodule

bind ring_prescaler ring_prescaler_checker #(
    .RATIO (RATIO),
    .HIGH  (HIGH_CYC)
) u_chk (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .ce_o    (ce_o)
);

// File: tb/sim_ring_prescaler.sv
// Bench: five configurations run side by side against a behavioural
// phase model, compared at every falling clock edge.
module sim_ring_prescaler;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ce;

    int n_edges = 0;
    int checks  = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // u0: 60 = 2*2*3*5, pulse mode
    ring_prescaler #(.IN_FREQ_HZ(60), .OUT_FREQ_HZ(1), .DUTY(0.0))  u0 (.clk_i(clk), .rst_n_i(rst_n), .ce_o(ce[0]));
    // u1: 29 prime, 0.3 -> 9 high
    ring_prescaler #(.IN_FREQ_HZ(29), .OUT_FREQ_HZ(1), .DUTY(0.3))  u1 (.clk_i(clk), .rst_n_i(rst_n), .ce_o(ce[1]));
    // u2: 4, 0.9 -> 3.6 rounds to 4, clamped to 3
    ring_prescaler #(.IN_FREQ_HZ(4),  .OUT_FREQ_HZ(1), .DUTY(0.9))  u2 (.clk_i(clk), .rst_n_i(rst_n), .ce_o(ce[2]));
    // u3: 60, 0.5 -> 30 high
    ring_prescaler #(.IN_FREQ_HZ(120),.OUT_FREQ_HZ(2), .DUTY(0.5))  u3 (.clk_i(clk), .rst_n_i(rst_n), .ce_o(ce[3]));
    // u4: 62 = 2*31, 0.001 -> 0 clamped to 1
    ring_prescaler #(.IN_FREQ_HZ(62), .OUT_FREQ_HZ(1), .DUTY(0.001)) u4 (.clk_i(clk), .rst_n_i(rst_n), .ce_o(ce[4]));

    function automatic int ratio_of(input int i);
        case (i)
            0: return 60;
            1: return 29;
            2: return 4;
            3: return 60;
            default: return 62;
        endcase
    endfunction

    function automatic int high_of(input int i);
        case (i)
            0: return 1;
            1: return 9;
            2: return 3;
            3: return 30;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R3";
            1: return "R7";
            2: return "R5";
            3: return "R2";
            default: return "R5";
        endcase
    endfunction

    // Reference phase: edges seen with reset released.
    always @(posedge clk) begin
        if (!rst_n) n_edges <= 0;
        else        n_edges <= n_edges + 1;
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < 5; i++) begin
                int r;
                int h;
                logic expv;
                string tg;
                r = ratio_of(i);
                h = high_of(i);
                expv = (n_edges >= r) && ((n_edges % r) < h);
                if (n_edges < r)                       tg = "R6";
                else if ((n_edges % r) == 0)           tg = "R1";
                else if (i == 1 || i == 3)             tg = "R4";
                else                                   tg = tag_of(i);
                checks++;
                if (ce[i] !== expv) begin
                    fails++;
                    $display("FAIL %s u%0d at edge %0d: got %b expected %b", tg, i, n_edges, ce[i], expv);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus: reset, long run, mid-period reset (R6), second run.
    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (437) @(negedge clk);
        rst_n = 1'b0;          // R6 restart in the middle of a period
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (400) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule